// File: doc/BRIEF.md
# Nibble-Serial Trace Address Receiver

This block captures branch-trace destination addresses that arrive four bits at a time. It samples a framing line (`sync_i`) and a 4-bit data bus on every rising edge of the trace clock. A cycle with the framing line high carries a command nibble. The command announces how many address nibbles follow. Cycles with the framing line low carry those address nibbles, least significant first, and each one is written into a working copy of the address.

A transfer may update only the low part of the address. Any nibbles it does not send keep the values of the last completed address. When the framing line goes high again after exactly the announced number of nibbles, the rebuilt address is placed on the output and a one-cycle strobe marks it. A transfer that ends early or overruns is dropped, and the output address is left as it was.

Top module: `trace_addr_rx`

## Requirements
- R1: While reset is asserted and at the first sample after it, `addr_o` is 0 and `addr_vld_o` is 0. The last address, the working address and the expected count are all zero.
- R2: With `sync_i` high, command nibbles 4'h8, 4'h9, 4'hA and 4'hB announce 1, 2, 4 and 8 address nibbles.
- R3: The nibble value has bit i equal to `nib_i[i]`. The k-th data nibble of a transfer (k = 0 first) lands in address bits [4k+3:4k].
- R4: A sync-high sample completes a transfer when the received count equals a non-zero announced count. After that clock edge, `addr_vld_o` is 1 and `addr_o` holds the rebuilt address.
- R5: A transfer of n nibbles with n < 8 changes only address bits [4n-1:0]. The upper bits keep the values of the last completed address.
- R6: Any command value other than 4'h8 to 4'hB, including the idle value 4'h3, announces zero nibbles. The data nibbles that follow are ignored and produce no strobe.
- R7: A sync-high sample that arrives before all the announced nibbles discards the transfer. There is no strobe, and the next transfer builds on the last completed address.
- R8: If more data nibbles arrive than were announced, the extras are not written and the transfer does not complete.
- R9: `addr_vld_o` is high for exactly one cycle per completed transfer. The completing sync-high sample may itself carry the next command.
- R10: `addr_o` changes only in a cycle in which `addr_vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Framing line: high = command nibble, low = address nibble |
| nib_i | input | 4 | Data bus, bit i = data line i |
| addr_o | output | 32 | Last completed destination address |
| addr_vld_o | output | 1 | One-cycle strobe for a newly completed address |

## Verification
Four properties are checked on every cycle:
- the reset value (R1)
- that the strobe never lasts two cycles (R9)
- that the strobe follows a data cycle and then a sync-high sample (R4)
- that the output address never changes without the strobe (R10)

Command decoding, nibble placement, merging with the upper bits, and the discarding of idle, early-ended and overrun transfers need real traffic. The bench's scenarios show these by comparing each outcome with an address model.

// File: rtl/trace_rx_pkg.sv
package trace_rx_pkg;
    localparam int NIB_W = 4;
    // Command nibbles carry 2'b10 in their top two bits; the low two bits give log2 of the length.
    localparam logic [1:0] CMD_TAG = 2'b10;
endpackage

// File: rtl/trace_cmd_decode.sv
module trace_cmd_decode
    import trace_rx_pkg::*;
#(
    parameter int NIB_CNT = 8,
    parameter int CNT_W   = 4
) (
    input  logic [NIB_W-1:0] cmd_i,
    output logic [CNT_W-1:0] len_o
);
    logic [CNT_W-1:0] raw_len;

    always_comb begin
        raw_len = CNT_W'(1) << cmd_i[1:0];
        if (cmd_i[NIB_W-1:NIB_W-2] != CMD_TAG || raw_len > CNT_W'(NIB_CNT))
            len_o = '0;
        else
            len_o = raw_len;
    end
endmodule

// File: rtl/trace_nib_insert.sv
module trace_nib_insert
    import trace_rx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic [ADDR_W-1:0] word_i,
    input  logic [CNT_W-1:0]  pos_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic [ADDR_W-1:0] word_o
);
    localparam int LANES = ADDR_W / NIB_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign word_o[k*NIB_W +: NIB_W] =
            (pos_i == CNT_W'(k)) ? nib_i : word_i[k*NIB_W +: NIB_W];
    end
endmodule

// File: rtl/trace_addr_rx.sv
module trace_addr_rx
    import trace_rx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o
);
    localparam int NIB_CNT = ADDR_W / NIB_W;
    localparam int CNT_W   = $clog2(NIB_CNT + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  expn;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
        logic [ADDR_W-1:0] work;
        logic [ADDR_W-1:0] last;
        logic              vld;
    } rx_state_t;

    rx_state_t         st_d, st_q;
    logic [CNT_W-1:0]  cmd_len;
    logic [ADDR_W-1:0] merged;
    logic              done;

    trace_cmd_decode #(.NIB_CNT(NIB_CNT), .CNT_W(CNT_W)) u_dec (
        .cmd_i (nib_i),
        .len_o (cmd_len)
    );

    trace_nib_insert #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ins (
        .word_i (st_q.work),
        .pos_i  (st_q.cnt),
        .nib_i  (nib_i),
        .word_o (merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        done     = 1'b0;
        if (sync_i) begin
            done = (st_q.expn != '0) && (st_q.cnt == st_q.expn) && !st_q.ovf;
            if (done) begin
                st_d.last = st_q.work;
                st_d.vld  = 1'b1;
            end
            st_d.work = done ? st_q.work : st_q.last;
            st_d.cnt  = '0;
            st_d.ovf  = 1'b0;
            st_d.expn = cmd_len;
        end else if (st_q.expn != '0) begin
            if (st_q.cnt < st_q.expn) begin
                st_d.work = merged;
                st_d.cnt  = st_q.cnt + CNT_W'(1);
            end else begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o     = st_q.last;
    assign addr_vld_o = st_q.vld;
endmodule

// File: rtl/trace_addr_rx_chk.sv
module trace_addr_rx_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              addr_vld_o
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (addr_o == '0 && !addr_vld_o));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld_o |=> !addr_vld_o);

    a_r4_after_data_then_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_vld_o) |-> ($past(sync_i) && !$past(sync_i, 2)));

    a_r10_addr_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_o) |-> addr_vld_o);
endmodule

bind trace_addr_rx trace_addr_rx_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (sync_i),
    .addr_o     (addr_o),
    .addr_vld_o (addr_vld_o)
);

// File: tb/test_trace_addr_rx.sv
module test_trace_addr_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b1;
    logic [3:0]  nib_i = 4'h3;
    logic [31:0] addr_o;
    logic        addr_vld_o;

    int checks = 0;
    int bad = 0;
    int pulses = 0;
    logic [31:0] model = 32'h0;

    always #4 clk = ~clk;

    trace_addr_rx i_trace_addr_rx (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .nib_i(nib_i),
        .addr_o(addr_o), .addr_vld_o(addr_vld_o)
    );

    always @(negedge clk) if (addr_vld_o) pulses++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one sample and return at the next falling edge, after the sampling edge.
    task automatic drive(input bit s, input logic [3:0] n);
        sync_i = s;
        nib_i  = n;
        @(negedge clk);
    endtask

    task automatic send(input logic [3:0] cmd, input int n, input logic [31:0] val, input logic [3:0] closer);
        drive(1'b1, cmd);
        for (int k = 0; k < n; k++) drive(1'b0, val[4*k +: 4]);
        drive(1'b1, closer);
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input int n, input logic [31:0] val);
        logic [31:0] m;
        m = (n >= 8) ? 32'hFFFF_FFFF : ((32'h1 << (4*n)) - 1);
        return (old & ~m) | (val & m);
    endfunction

    task automatic good_xfer(input logic [3:0] cmd, input int n, input logic [31:0] val, input string req);
        model = merge(model, n, val);
        send(cmd, n, val, 4'h3);
        chk(addr_vld_o === 1'b1, {"R4 ", req}, {31'h0, addr_vld_o}, 32'h1);
        chk(addr_o === model, {"R3 ", req}, addr_o, model);
        drive(1'b1, 4'h3);
        chk(addr_vld_o === 1'b0, "R9 strobe width", {31'h0, addr_vld_o}, 32'h0);
    endtask

    task automatic no_xfer(input logic [3:0] cmd, input int n, input logic [31:0] val, input string req);
        int p0;
        #1 p0 = pulses;
        send(cmd, n, val, 4'h3);
        drive(1'b1, 4'h3);
        drive(1'b1, 4'h3);
        #1;
        chk(pulses == p0, req, pulses, p0);
        chk(addr_o === model, {req, " R10 addr"}, addr_o, model);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(addr_o === 32'h0 && addr_vld_o === 1'b0, "R1 during reset", addr_o, 32'h0);
        rst_n = 1'b1;
        drive(1'b1, 4'h3);
        chk(addr_o === 32'h0 && addr_vld_o === 1'b0, "R1 after reset", addr_o, 32'h0);
    endtask

    task automatic t_full;
        good_xfer(4'hB, 8, 32'h1234_5678, "R2 cmd B");
        good_xfer(4'hB, 8, 32'h8421_C3A5, "R2 bit order");
    endtask

    task automatic t_partial;
        good_xfer(4'h8, 1, 32'h0000_000F, "R2 R5 one nibble");
        good_xfer(4'h9, 2, 32'h0000_0096, "R2 R5 two nibbles");
        good_xfer(4'hA, 4, 32'h0000_BEEF, "R2 R5 four nibbles");
    endtask

    task automatic t_undefined;
        no_xfer(4'h3, 4, 32'h0000_1111, "R6 idle cmd");
        no_xfer(4'h7, 2, 32'h0000_0022, "R6 cmd 7");
        no_xfer(4'hC, 8, 32'h3333_3333, "R6 cmd C");
    endtask

    task automatic t_early;
        no_xfer(4'hA, 2, 32'h0000_0055, "R7 early end");
        good_xfer(4'h9, 2, 32'h0000_0071, "R7 resume from last");
    endtask

    task automatic t_overrun;
        no_xfer(4'h8, 3, 32'h0000_0ABC, "R8 overrun");
        good_xfer(4'h8, 1, 32'h0000_0004, "R8 next after overrun");
    endtask

    task automatic t_back2back;
        logic [31:0] first;
        first = merge(model, 2, 32'h0000_00E1);
        send(4'h9, 2, 32'h0000_00E1, 4'h8);
        chk(addr_vld_o === 1'b1 && addr_o === first, "R9 first of pair", addr_o, first);
        model = merge(first, 1, 32'h0000_0006);
        drive(1'b0, 4'h6);
        chk(addr_vld_o === 1'b0, "R9 no repeat", {31'h0, addr_vld_o}, 32'h0);
        drive(1'b1, 4'h3);
        chk(addr_vld_o === 1'b1 && addr_o === model, "R9 second of pair", addr_o, model);
        drive(1'b1, 4'h3);
    endtask

    initial begin
        t_reset;
        t_full;
        t_partial;
        t_undefined;
        t_early;
        t_overrun;
        t_back2back;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule